// File: doc/BRIEF.md
# Push-Pull PWM Pulse Steering Controller

This block is a fully digital fixed-frequency pulse-width modulator for a power stage with two switches. They can be driven as a push-pull pair or used single-ended. A free-running period counter acts as the ramp, and an active-low sync input can restart it. Each period, the count is compared against a duty word and a dead-time word. The resulting pulse goes to driver A or driver B in strict alternation. A latch allows only one pulse per period, and a current-limit input can end the pulse early.

Four conditions hold both drivers off: an active-low shutdown, an active-low soft-start restart, an active-high supply-low flag, and the block reset. When these clear, a soft-start ramp limits the effective duty word and then widens it period by period up to the commanded value.

Each period is handled by one controller with four states:
- HOLD: the drivers are off while the block is disabled. On a period start with the block enabled, it goes to BLANK.
- BLANK: the start of the period, covered by the dead time. If the window opens, it goes to PULSE. If current limit is active or the window has already closed, it goes to SPENT.
- PULSE: one driver is on. On current limit or when the count reaches the effective duty, it goes to SPENT.
- SPENT: the pulse is over for this period. On the next period start, it goes to BLANK.

From any state, loss of enable leads to HOLD. From any state other than HOLD, a period start leads to BLANK.

Top module: `pwm_pushpull_ctrl`

## Requirements
- R1: After the pulse of a period has ended, no new pulse starts before the next period start, even if the duty word is raised within the period.
- R2: Pulses alternate between drv_a and drv_b, and the first pulse after reset goes to drv_a.
- R3: The alternation survives periods without a pulse: the pulse after any number of empty periods goes to the driver that did not fire last.
- R4: With count c running 0..PERIOD-1, a driver is high for count values with max(dead_cmd,1) <= c < min(effective duty, PERIOD). In steady state, the pulse width is min(duty_cmd,PERIOD) - max(dead_cmd,1) clocks, at most PERIOD-1, and the low gap before the next pulse is PERIOD minus that width.
- R5: A period lasts PERIOD clocks. Both drivers are low while the count is 0, the drivers are never high together, and a driver never rises in the clock right after the other one was high.
- R6: A duty word of 0 or 1, or one not above max(dead_cmd,1), gives no pulse at all.
- R7: A high ilim that is sampled by two synchronizer stages turns the active pulse off on the next clock. A one-clock ilim that arrives in the first pulse clock leaves a 3-clock pulse. The driver stays off for the rest of the period.
- R8: A low shutdown_n or restart_n turns the drivers off at most 3 clocks after it is applied, keeps them off, and clears the soft-start ramp.
- R9: A high supply_low has the same effect as R8. After release, a fresh soft-start begins.
- R10: Soft-start: in the k-th period after enable, the effective duty is min(duty_cmd, k*SS_STEP, PERIOD). Enable takes effect at the next period start. With duty_cmd=20 and dead_cmd=1, the first two pulses are 3 and 7 clocks wide.
- R11: A falling edge on sync_n restarts the count at 0. If sync_n is driven low in the first clock of a pulse, that pulse lasts 3 clocks and the next pulse starts after max(dead_cmd,1) low clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous block reset, active low |
| shutdown_n | input | 1 | Asynchronous shutdown request, active low |
| restart_n | input | 1 | Asynchronous soft-start restart, active low |
| sync_n | input | 1 | Asynchronous period sync; a falling edge restarts the count |
| supply_low | input | 1 | Asynchronous undervoltage flag, active high |
| ilim | input | 1 | Asynchronous current-limit trip, active high |
| duty_cmd | input | CW | Pulse end count |
| dead_cmd | input | CW | Pulse earliest start count |
| drv_a | output | 1 | Driver A pulse |
| drv_b | output | 1 | Driver B pulse |

## Verification
The hardest cases to reach are those where a pulse ends early: a current-limit trip or a sync restart that arrives exactly in the first clock of a pulse, and a duty raise in the clock right after the pulse ended. The bench waits for the driver to rise, then drives the trigger on that same sample, so the 3-clock width and the following gap are exact. Randomly chosen duty and dead-time words, including empty windows, run between directed cases. A monitor that is always active tracks the driver order across all of them.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_BLANK = 2'd1,
        ST_PULSE = 2'd2,
        ST_SPENT = 2'd3
    } steer_state_t;

endpackage

// File: rtl/pwm_sync2.sv
module pwm_sync2 #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
    parameter int PERIOD = 32,
    parameter int CW     = 6
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          sync_s_n,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_next_o,
    output logic          start_next_o
);

    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;
    logic          sync_prev_q;
    logic          restart;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q       <= '0;
            sync_prev_q <= 1'b1;
        end else begin
            cnt_q       <= cnt_next_o;
            sync_prev_q <= sync_s_n;
        end
    end

    // falling edge of the synchronized sync line forces a new period
    assign restart = sync_prev_q & ~sync_s_n;

    always_comb begin
        if (restart || (cnt_q == LAST)) cnt_next_o = '0;
        else                            cnt_next_o = cnt_q + 1'b1;
    end

    assign start_next_o = (cnt_next_o == '0);
    assign cnt_o        = cnt_q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!arst_n)
        cnt_q <= LAST); // R5
    AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!arst_n)
        restart |=> (cnt_q == '0)); // R11

endmodule

// File: rtl/pwm_softstart.sv
module pwm_softstart #(
    parameter int PERIOD  = 32,
    parameter int SS_STEP = 4,
    parameter int CW      = 6
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          run_i,
    input  logic          start_i,
    input  logic [CW-1:0] duty_cmd_i,
    output logic [CW-1:0] duty_eff_o
);

    localparam logic [CW-1:0] SS_TOP = CW'(PERIOD);
    localparam logic [CW-1:0] SS_INC = CW'(SS_STEP);

    logic [CW-1:0] ramp_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ramp_q <= '0;
        end else if (!run_i) begin
            ramp_q <= '0;
        end else if (start_i) begin
            if (ramp_q >= SS_TOP - SS_INC) ramp_q <= SS_TOP;
            else                           ramp_q <= ramp_q + SS_INC;
        end
    end

    assign duty_eff_o = (duty_cmd_i < ramp_q) ? duty_cmd_i : ramp_q;

    AST_SS_NO_DROP: assert property (@(posedge clk) disable iff (!arst_n)
        (run_i && $past(run_i)) |-> (ramp_q >= $past(ramp_q))); // R10
    AST_SS_CLEARED: assert property (@(posedge clk) disable iff (!arst_n)
        !run_i |=> (ramp_q == '0)); // R8

endmodule

// File: rtl/pwm_steer_fsm.sv
module pwm_steer_fsm
    import pwm_steer_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          run_i,
    input  logic          ilim_i,
    input  logic          start_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] cnt_next_i,
    input  logic [CW-1:0] dead_i,
    input  logic [CW-1:0] duty_i,
    output logic          out_a_o,
    output logic          out_b_o
);

    steer_state_t state_q;
    steer_state_t state_d;
    logic         last_b_q;   // 1: the most recent pulse went to driver B
    logic         window_open;
    logic         window_over;
    logic         pulse_on;

    assign window_open = (cnt_next_i >= dead_i) && (cnt_next_i < duty_i);
    assign window_over = (cnt_next_i >= duty_i);

    always_comb begin
        state_d = state_q;
        if (!run_i) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:  if (start_i) state_d = ST_BLANK;
                ST_BLANK: begin
                    if (start_i)          state_d = ST_BLANK;
                    else if (ilim_i)      state_d = ST_SPENT;
                    else if (window_open) state_d = ST_PULSE;
                    else if (window_over) state_d = ST_SPENT;
                end
                ST_PULSE: begin
                    if (start_i)                    state_d = ST_BLANK;
                    else if (ilim_i || window_over) state_d = ST_SPENT;
                end
                ST_SPENT: if (start_i) state_d = ST_BLANK;
            endcase
        end
    end

    // state register and steering memory
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q  <= ST_HOLD;
            last_b_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if ((state_d == ST_PULSE) && (state_q != ST_PULSE))
                last_b_q <= ~last_b_q;
        end
    end

    // driver outputs
    always_comb begin
        out_a_o = (state_q == ST_PULSE) && !last_b_q;
        out_b_o = (state_q == ST_PULSE) &&  last_b_q;
    end

    assign pulse_on = out_a_o | out_b_o;

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!arst_n)
        !(out_a_o && out_b_o)); // R5
    AST_ZERO_COUNT_LOW: assert property (@(posedge clk) disable iff (!arst_n)
        (cnt_i == '0) |-> !pulse_on); // R5
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!arst_n)
        ((state_q == ST_SPENT) && !start_i) |=> (state_q != ST_PULSE)); // R1
    AST_ILIM_CUT: assert property (@(posedge clk) disable iff (!arst_n)
        ilim_i |=> !pulse_on); // R7
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!arst_n)
        !run_i |=> !pulse_on); // R8
    AST_LATE_START: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(pulse_on) |-> (cnt_i >= $past(dead_i))); // R4
    AST_DUTY_END: assert property (@(posedge clk) disable iff (!arst_n)
        pulse_on |-> (cnt_i < $past(duty_i))); // R4

endmodule

// File: rtl/pwm_pushpull_ctrl.sv
module pwm_pushpull_ctrl #(
    parameter  int PERIOD  = 32,
    parameter  int SS_STEP = 4,
    localparam int CW      = $clog2(PERIOD) + 1
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          shutdown_n,
    input  logic          restart_n,
    input  logic          sync_n,
    input  logic          supply_low,
    input  logic          ilim,
    input  logic [CW-1:0] duty_cmd,
    input  logic [CW-1:0] dead_cmd,
    output logic          drv_a,
    output logic          drv_b
);

    // bit order: shutdown_n, restart_n, sync_n, supply_low, ilim
    localparam logic [4:0] ASYNC_RST = 5'b11110;

    logic [4:0]    async_s;
    logic          shdn_s_n;
    logic          rst_s_n;
    logic          sync_s_n;
    logic          low_s;
    logic          ilim_s;
    logic          run;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_next;
    logic          start_next;
    logic [CW-1:0] duty_eff;

    pwm_sync2 #(.W(5), .RST_VAL(ASYNC_RST)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d_i    ({shutdown_n, restart_n, sync_n, supply_low, ilim}),
        .q_o    (async_s)
    );

    assign {shdn_s_n, rst_s_n, sync_s_n, low_s, ilim_s} = async_s;
    assign run = shdn_s_n & rst_s_n & ~low_s;

    pwm_period_ctr #(.PERIOD(PERIOD), .CW(CW)) u_ctr (
        .clk          (clk),
        .arst_n       (arst_n),
        .sync_s_n     (sync_s_n),
        .cnt_o        (cnt),
        .cnt_next_o   (cnt_next),
        .start_next_o (start_next)
    );

    pwm_softstart #(.PERIOD(PERIOD), .SS_STEP(SS_STEP), .CW(CW)) u_ss (
        .clk        (clk),
        .arst_n     (arst_n),
        .run_i      (run),
        .start_i    (start_next),
        .duty_cmd_i (duty_cmd),
        .duty_eff_o (duty_eff)
    );

    pwm_steer_fsm #(.CW(CW)) u_fsm (
        .clk        (clk),
        .arst_n     (arst_n),
        .run_i      (run),
        .ilim_i     (ilim_s),
        .start_i    (start_next),
        .cnt_i      (cnt),
        .cnt_next_i (cnt_next),
        .dead_i     (dead_cmd),
        .duty_i     (duty_eff),
        .out_a_o    (drv_a),
        .out_b_o    (drv_b)
    );

    AST_SUPPLY_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
        low_s |=> !(drv_a || drv_b)); // R9

endmodule

// File: tb/pwm_pushpull_ctrl_tb.sv
module pwm_pushpull_ctrl_tb_top;

    localparam int P  = 32;
    localparam int SS = 4;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          arst_n, shutdown_n, restart_n, sync_n, supply_low, ilim;
    logic [CW-1:0] duty_cmd, dead_cmd;
    logic          drv_a, drv_b;

    int n_chk = 0;
    int n_bad = 0;
    int last_side = 1;
    logic pa = 1'b0, pb = 1'b0;

    always #5 clk = ~clk;

    pwm_pushpull_ctrl #(.PERIOD(P), .SS_STEP(SS)) dut_i (
        .clk(clk), .arst_n(arst_n), .shutdown_n(shutdown_n), .restart_n(restart_n),
        .sync_n(sync_n), .supply_low(supply_low), .ilim(ilim),
        .duty_cmd(duty_cmd), .dead_cmd(dead_cmd), .drv_a(drv_a), .drv_b(drv_b)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_width(input int duty, input int dead);
        int hi = (duty > P) ? P : duty;
        int lo = (dead < 1) ? 1 : dead;
        return (hi > lo) ? hi - lo : 0;
    endfunction

    // continuous order and overlap monitor
    always @(negedge clk) begin
        if (arst_n) begin
            if (drv_a && drv_b) check(1'b0, "R5 both drivers high", 1, 0);
            if (drv_a && !pa) begin
                check(!pb, "R5 no gap before A", int'(pb), 0);
                check(last_side == 1, "R2 alternation on A", last_side, 1);
                last_side = 0;
            end
            if (drv_b && !pb) begin
                check(!pa, "R5 no gap before B", int'(pa), 0);
                check(last_side == 0, "R2 alternation on B", last_side, 0);
                last_side = 1;
            end
        end
        pa <= drv_a;
        pb <= drv_b;
    end

    task automatic get_pulse(output int gap, output int w, output int side);
        gap = 0; w = 0; side = -1;
        while (!(drv_a || drv_b) && gap < 4 * P) begin
            gap++;
            @(negedge clk);
        end
        if (!(drv_a || drv_b)) begin
            check(1'b0, "R4 pulse expected", 0, 1);
            return;
        end
        side = drv_a ? 0 : 1;
        while ((drv_a || drv_b) && w < 2 * P) begin
            w++;
            @(negedge clk);
        end
    endtask

    task automatic quiet(input int n, input string req);
        int hi = 0;
        repeat (n) begin
            @(negedge clk);
            if (drv_a || drv_b) hi++;
        end
        check(hi == 0, req, hi, 0);
    endtask

    task automatic wait_rise();
        int t = 0;
        while (!(drv_a || drv_b) && t < 4 * P) begin
            t++;
            @(negedge clk);
        end
    endtask

    initial begin
        int g, w, s, s0, seed_use, duty, dead, ew;
        seed_use = $urandom(32'd5150);
        arst_n = 0; shutdown_n = 1; restart_n = 1; sync_n = 1;
        supply_low = 0; ilim = 0; duty_cmd = 6'd20; dead_cmd = 6'd1;
        repeat (4) @(negedge clk);
        check(!drv_a && !drv_b, "R8 reset state drivers low", int'(drv_a | drv_b), 0);
        arst_n = 1;
        quiet(30, "R10 no pulse before first period");
        get_pulse(g, w, s);
        check(w == 3, "R10 first soft-start pulse", w, 3);
        check(s == 0, "R2 first pulse on A", s, 0);
        get_pulse(g, w, s);
        check(w == 7, "R10 second soft-start pulse", w, 7);
        repeat (10 * P) @(negedge clk);

        // steady window
        get_pulse(g, w, s);
        get_pulse(g, w, s);
        check(w == 19, "R4 steady width", w, 19);
        check(g == P - 19, "R4 steady gap", g, P - 19);

        // maximum duty
        duty_cmd = 6'(P + 10); dead_cmd = 6'd0;
        repeat (2 * P) @(negedge clk);
        get_pulse(g, w, s);
        get_pulse(g, w, s);
        check(w == P - 1, "R4 max width", w, P - 1);
        check(g == 1, "R5 boundary gap", g, 1);

        // empty windows
        duty_cmd = 6'd1; dead_cmd = 6'd0;
        repeat (2 * P) @(negedge clk);
        quiet(3 * P, "R6 duty at ramp minimum");
        duty_cmd = 6'd10; dead_cmd = 6'd12;
        repeat (2 * P) @(negedge clk);
        quiet(3 * P, "R6 duty below dead time");

        // memory across empty periods
        duty_cmd = 6'd8; dead_cmd = 6'd1;
        repeat (2 * P) @(negedge clk);
        get_pulse(g, w, s0);
        duty_cmd = 6'd0;
        quiet(3 * P, "R3 skipped periods silent");
        duty_cmd = 6'd8;
        get_pulse(g, w, s);
        check(s != s0, "R3 side after skipped periods", s, 1 - s0);
        check(w == 7, "R3 width after skip", w, 7);

        // metering: raise duty right after the pulse ended
        get_pulse(g, w, s);
        duty_cmd = 6'(P);
        get_pulse(g, w, s);
        check(g == P - 7, "R1 no second pulse in period", g, P - 7);
        check(w == P - 1, "R1 next period width", w, P - 1);

        // current limit in first pulse clock
        dead_cmd = 6'd4;
        repeat (2 * P) @(negedge clk);
        get_pulse(g, w, s);
        wait_rise();
        ilim = 1; w = 0;
        while ((drv_a || drv_b) && w < 2 * P) begin
            w++;
            @(negedge clk);
            if (w == 1) ilim = 0;
        end
        check(w == 3, "R7 cut pulse width", w, 3);
        get_pulse(g, w, s);
        check(g == P - 3, "R7 off for rest of period", g, P - 3);
        check(w == P - 4, "R7 next pulse full", w, P - 4);

        // sync restart in first pulse clock
        wait_rise();
        sync_n = 0; w = 0;
        while ((drv_a || drv_b) && w < 2 * P) begin
            w++;
            @(negedge clk);
            if (w == 1) sync_n = 1;
        end
        check(w == 3, "R11 pulse cut by sync", w, 3);
        get_pulse(g, w, s);
        check(g == 4, "R11 restart gap", g, 4);
        check(w == P - 4, "R11 width after restart", w, P - 4);

        // hold sources: shutdown, restart, supply low
        duty_cmd = 6'd20; dead_cmd = 6'd1;
        for (int k = 0; k < 3; k++) begin
            repeat (2 * P) @(negedge clk);
            wait_rise();
            if (k == 0) shutdown_n = 0;
            else if (k == 1) restart_n = 0;
            else supply_low = 1;
            repeat (3) @(negedge clk);
            check(!drv_a && !drv_b, (k == 2) ? "R9 supply low cut" : "R8 hold cut", int'(drv_a | drv_b), 0);
            quiet(2 * P, (k == 2) ? "R9 held off" : "R8 held off");
            shutdown_n = 1; restart_n = 1; supply_low = 0;
            get_pulse(g, w, s);
            check(w == 3, (k == 2) ? "R9 soft-start restarts" : "R8 soft-start restarts", w, 3);
            get_pulse(g, w, s);
            check(w == 7, "R10 ramp step", w, 7);
            repeat (10 * P) @(negedge clk);
        end

        // random windows
        for (int it = 0; it < 24; it++) begin
            duty = int'($urandom_range(P + 4, 0));
            dead = int'($urandom_range(P / 2, 0));
            duty_cmd = 6'(duty); dead_cmd = 6'(dead);
            ew = exp_width(duty, dead);
            repeat (2 * P) @(negedge clk);
            if (ew == 0) begin
                quiet(3 * P, "R6 random empty window");
            end else begin
                get_pulse(g, w, s);
                for (int j = 0; j < 2; j++) begin
                    get_pulse(g, w, s);
                    check(w == ew, "R4 random width", w, ew);
                    check(g == P - ew, "R4 random gap", g, P - ew);
                end
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule